// File: doc/BRIEF.md
# Flash Control Register with Cross-Bit Interlocks

This block is the byte-wide control register that sits in front of an on-chip flash array and its charge pump. Software selects an operation (program, erase or margin read), a block-erase size, a charge-pump clock ratio and finally turns high voltage on. Every bus write is passed through an interlock filter before it is stored. The filter keeps the register out of combinations that could damage the array or corrupt data: high voltage without an operation selected, program and erase together, and margin read while high voltage is on.

The stored byte drives the array-side outputs directly. These are a decoded operation mode, the array high-voltage and pump-on enables, the block size code and the divide select. A charge-pump tick output pulses once every 1, 2, 4 or 8 system clocks, and only while high voltage is enabled. The reset input is asynchronous and active low. It is released synchronously, two clock edges after it rises.

Byte layout: bit 0 program select, bit 1 erase select, bit 2 margin read, bit 3 high-voltage enable, bits 5:4 block-size code, bits 7:6 pump divide code.

Top module: `flash_ctl_intlk`

## Requirements
- R1: The read port always returns the stored byte, laid out as bit 0 program, bit 1 erase, bit 2 margin, bit 3 high voltage, bits 5:4 block code, bits 7:6 divide code. A legal write reads back unchanged.
- R2: High voltage (bit 3) is stored as 1 only if program or erase was already 1 before the write. Otherwise a write with bit 3 set leaves it at 0.
- R3: Program and erase never both read as 1. A write that sets both keeps erase and stores program as 0.
- R4: Margin read (bit 2) is stored as 0 whenever the write leaves high voltage at 1, even if bit 2 was written as 1.
- R5: A write that clears both program and erase clears high voltage on the same clock edge, whatever bit 3 carries.
- R6: hv_array_o and pump_on_o equal the stored high-voltage bit.
- R7: mode_o is 2 when erase is set, otherwise 1 when program is set, otherwise 3 when margin is set, otherwise 0.
- R8: blk_size_o equals bits 5:4 and div_sel_o equals bits 7:6 of the stored byte.
- R9: While high voltage is 1, pump_tick_o pulses once every 2^div_sel_o cycles, with the first pulse in cycle 2^div_sel_o after high voltage rises. It is 0 whenever high voltage is 0.
- R10: Reset clears every bit to 0. A cycle with wr_en_i at 0 leaves the register unchanged, whatever wdata_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Stored control byte |
| mode_o | output | 2 | Decoded operation: 0 idle, 1 program, 2 erase, 3 margin read |
| hv_array_o | output | 1 | High voltage routed to the array |
| pump_on_o | output | 1 | Charge pump enabled |
| blk_size_o | output | 2 | Block-erase size code |
| div_sel_o | output | 2 | Charge-pump divide select |
| pump_tick_o | output | 1 | Charge-pump clock pulse, period 2^div_sel_o |

## Verification
The hardest state to reach is high voltage at 1. It needs an earlier write that selects program or erase, followed by a write that repeats the selection and adds bit 3. The stimulus walks through that two-step sequence before it tries to violate each interlock from the armed state: setting margin read, clearing the selection, and swapping program for erase. The pump tick is then counted over fixed windows for every divide code, after arming from a clean register each time.

// File: rtl/flash_ctl_pkg.sv
package flash_ctl_pkg;
  localparam int DATA_W = 8;
  localparam int BLK_W  = 2;
  localparam int DIV_W  = 2;
  localparam int CNT_W  = (1 << DIV_W) - 1;

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [BLK_W-1:0] blk;
    logic             hv;
    logic             margin;
    logic             erase;
    logic             prog;
  } fcr_t;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_PROG   = 2'd1,
    MODE_ERASE  = 2'd2,
    MODE_MARGIN = 2'd3
  } fmode_e;
endpackage

// File: rtl/flash_ctl_wrfilter.sv
module flash_ctl_wrfilter
  import flash_ctl_pkg::*;
(
  input  logic  old_sel_i,
  input  fcr_t  req_i,
  output fcr_t  next_o
);
  logic erase_n;
  logic prog_n;
  logic hv_n;

  always_comb begin
    erase_n = req_i.erase;
    prog_n  = req_i.prog & ~req_i.erase;
    hv_n    = req_i.hv & old_sel_i & (prog_n | erase_n);
    next_o        = req_i;
    next_o.erase  = erase_n;
    next_o.prog   = prog_n;
    next_o.hv     = hv_n;
    next_o.margin = req_i.margin & ~hv_n;
  end
endmodule

// File: rtl/flash_ctl_regs.sv
module flash_ctl_regs
  import flash_ctl_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n,
  input  logic en_i,
  input  fcr_t d_i,
  output fcr_t q_o
);
  fcr_t q_q;
  fcr_t q_d;

  always_comb begin
    q_d = q_q;
    if (en_i) q_d = d_i;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  p_hv_rise_needs_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(q_q.hv) |-> $past(q_q.prog | q_q.erase));
  p_no_prog_erase_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(q_q.prog && q_q.erase));
  p_margin_excl_hv_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(q_q.margin && q_q.hv));
  p_hv_implies_sel_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    q_q.hv |-> (q_q.prog || q_q.erase));
  p_hold_no_write_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> $stable(q_q));
endmodule

// File: rtl/flash_ctl_pump_div.sv
module flash_ctl_pump_div
  import flash_ctl_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] lim;
  logic             wrap;

  assign lim  = CNT_W'((1 << div_i) - 1);
  assign wrap = (cnt_q >= lim);

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)    cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i & wrap;

  p_tick_needs_hv_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o |-> run_i);
  p_cnt_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/flash_ctl_intlk.sv
module flash_ctl_intlk
  import flash_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_n_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [1:0]        mode_o,
  output logic              hv_array_o,
  output logic              pump_on_o,
  output logic [BLK_W-1:0]  blk_size_o,
  output logic [DIV_W-1:0]  div_sel_o,
  output logic              pump_tick_o
);
  logic   rst_meta_q;
  logic   rst_n;
  fcr_t   cur;
  fcr_t   filt;
  fmode_e mode;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  flash_ctl_wrfilter u_filt (
    .old_sel_i (cur.prog | cur.erase),
    .req_i     (fcr_t'(wdata_i)),
    .next_o    (filt)
  );

  flash_ctl_regs u_regs (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .en_i  (wr_en_i),
    .d_i   (filt),
    .q_o   (cur)
  );

  flash_ctl_pump_div u_pump (
    .clk_i  (clk_i),
    .rst_n  (rst_n),
    .run_i  (cur.hv),
    .div_i  (cur.div),
    .tick_o (pump_tick_o)
  );

  always_comb begin
    if (cur.erase)       mode = MODE_ERASE;
    else if (cur.prog)   mode = MODE_PROG;
    else if (cur.margin) mode = MODE_MARGIN;
    else                 mode = MODE_IDLE;
  end

  assign rdata_o    = cur;
  assign mode_o     = mode;
  assign hv_array_o = cur.hv;
  assign pump_on_o  = cur.hv;
  assign blk_size_o = cur.blk;
  assign div_sel_o  = cur.div;

  p_hv_outputs_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
    hv_array_o == pump_on_o);
  p_erase_mode_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    rdata_o[1] |-> (mode_o == 2'd2));
endmodule

// File: tb/flash_ctl_intlk_tb_top.sv
`timescale 1ns/1ps
module flash_ctl_intlk_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_n_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [1:0] mode_o;
  logic       hv_array_o;
  logic       pump_on_o;
  logic [1:0] blk_size_o;
  logic [1:0] div_sel_o;
  logic       pump_tick_o;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];
  logic [7:0] shadow = 8'h00;

  always #5 clk_i = ~clk_i;

  flash_ctl_intlk dut_i (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .mode_o(mode_o), .hv_array_o(hv_array_o),
    .pump_on_o(pump_on_o), .blk_size_o(blk_size_o), .div_sel_o(div_sel_o),
    .pump_tick_o(pump_tick_o)
  );

  // Expected stored byte derived from R2..R5 interlock rules.
  function automatic logic [7:0] expect_byte(logic [7:0] old, logic [7:0] d);
    logic er, pr, hv, mg;
    er = d[1];
    pr = d[0] & ~d[1];
    hv = d[3] & (old[0] | old[1]) & (pr | er);
    mg = d[2] & ~hv;
    return {d[7:4], hv, mg, er, pr};
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // Driver: one write, expected readback pushed to the scoreboard.
  task automatic wr(logic [7:0] d, string tag);
    item_t it;
    @(negedge clk_i);
    wr_en_i = 1'b1;
    wdata_i = d;
    @(posedge clk_i);
    #1;
    wr_en_i = 1'b0;
    shadow = expect_byte(shadow, d);
    it.exp = shadow;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: compares readback one half-cycle after the write edge.
  always @(negedge clk_i) begin
    while (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(it.tag, rdata_o, it.exp);
    end
  end

  task automatic tick_window(int div);
    int cnt;
    int first;
    wr({div[1:0], 2'b00, 4'b0001}, "R1 arm prog");
    wr({div[1:0], 2'b00, 4'b1001}, "R2 hv on");
    cnt = 0;
    first = -1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      if (pump_tick_o) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    check("R9 tick count", cnt, 16 >> div);
    check("R9 first tick", first, (1 << div) - 1);
    wr(8'h00, "R5 clear");
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      if (pump_tick_o) cnt++;
    end
    check("R9 no tick hv off", cnt, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R10 reset rdata", rdata_o, 0);
    check("R10 reset mode", mode_o, 0);
    check("R6 reset hv", {hv_array_o, pump_on_o, pump_tick_o}, 0);

    wr(8'h08, "R2 hv without selection");
    wr(8'h03, "R3 prog+erase");
    @(negedge clk_i);
    check("R7 erase mode", mode_o, 2);
    wr(8'h0A, "R2 hv with erase");
    @(negedge clk_i);
    check("R6 hv array", hv_array_o, 1);
    check("R6 pump on", pump_on_o, 1);
    wr(8'h0E, "R4 margin while hv");
    wr(8'h09, "R3 swap to prog keeps hv");
    @(negedge clk_i);
    check("R7 prog mode", mode_o, 1);
    wr(8'h08, "R5 clear selection drops hv");
    @(negedge clk_i);
    check("R6 hv off", {hv_array_o, pump_on_o}, 0);
    wr(8'h04, "R4 margin alone");
    @(negedge clk_i);
    check("R7 margin mode", mode_o, 3);
    wr(8'h05, "R1 prog+margin");
    @(negedge clk_i);
    check("R7 prog over margin", mode_o, 1);
    wr(8'hB1, "R1 fields");
    @(negedge clk_i);
    check("R8 blk", blk_size_o, 3);
    check("R8 div", div_sel_o, 2);
    wr(8'h00, "R1 zero");
    @(negedge clk_i);
    check("R7 idle mode", mode_o, 0);

    // R10: strobe low, data present, nothing stored
    wr(8'h02, "R1 erase");
    @(negedge clk_i);
    wdata_i = 8'hFF;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R10 no write ignored", rdata_o, 8'h02);
    wr(8'h00, "R1 zero");

    for (int d = 0; d < 4; d++) tick_window(d);

    // R10: asynchronous reset from an armed state
    wr(8'h02, "R1 erase");
    wr(8'h4A, "R2 hv");
    @(negedge clk_i);
    rst_n_i = 1'b0;
    #1;
    check("R10 reset clears", rdata_o, 0);
    shadow = 8'h00;
    @(negedge clk_i);
    rst_n_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R10 after reset", {rdata_o, pump_tick_o}, 0);

    @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule